// File: doc/BRIEF.md
# Windowed Link Lock Monitor

This block watches a serial link that has already been brought into lock, one received frame at a time. Each frame strobe presents two framing clock bits and one encoding bit. The clock bits are compared with fixed expected values. The encoding bit is compared with one position of a 130-frame alignment pattern that repeats without end. The mismatches are added up over each window of 130 frames. When the running count reaches a threshold, the lock output drops.

The threshold defaults to 3. A programmable value replaces the default only while its enable input is high. The clock-bit comparisons can be left out of the count. In that case only pattern mismatches can cause a drop. Lock comes up only on a relock pulse, which also restarts the pattern position, the window and the count. After a drop, lock stays low until the next relock pulse.

Top module: `link_lock_monitor`

## Requirements
- R1: After reset, `lock_o` is 0 and `err_cnt_o` is 0, and frame strobes have no effect on either output until a relock pulse arrives.
- R2: A cycle with `relock_i` high sets `lock_o` to 1 and `err_cnt_o` to 0 from the next cycle, and puts the pattern position back to 0. This takes priority over a frame strobe in the same cycle.
- R3: While `clkchk_en_i` is 1, each framing clock bit that differs from its expected value adds 1 error. The expected value of `clk_bit0_i` is 1 and that of `clk_bit1_i` is 0. While `clkchk_en_i` is 0, the clock bits add nothing.
- R4: On every locked frame, `enc_bit_i` is compared with bit `k` of `SEQ_PATTERN`, where `k` is 0 on the first frame after relock and rises by one per frame, wrapping from 129 to 0. A mismatch adds 1 error.
- R5: All errors of one frame (up to 3) are added in a single update, one cycle after the strobe.
- R6: After the 130th frame of a window, the count returns to 0 unless that frame reached the threshold.
- R7: While `thresh_en_i` is 0, the threshold is 3, whatever value `thresh_i` holds.
- R8: While `thresh_en_i` is 1, the threshold is `thresh_i`, and a value of 0 is treated as 1.
- R9: When the count plus the errors of a frame reaches the threshold or more, `lock_o` goes to 0 and `err_cnt_o` holds the threshold, both from the next cycle. They stay that way until a relock pulse.
- R10: Cycles with no frame strobe leave `lock_o`, `err_cnt_o` and the pattern position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| relock_i | input | 1 | Pulse: lock established, restart monitoring |
| frame_vld_i | input | 1 | One received frame is presented this cycle |
| clk_bit0_i | input | 1 | First framing clock bit of the frame |
| clk_bit1_i | input | 1 | Second framing clock bit of the frame |
| enc_bit_i | input | 1 | Encoding bit of the frame |
| thresh_i | input | TH_W | Programmable error threshold |
| thresh_en_i | input | 1 | Use `thresh_i` instead of the default threshold |
| clkchk_en_i | input | 1 | Count framing clock bit mismatches |
| lock_o | output | 1 | Lock flag |
| err_cnt_o | output | TH_W | Errors counted in the current window |

## Verification
Two functions can fall in the same cycle, and the bench forces both cases. In the first, the window boundary meets a threshold crossing: two errors are placed early in a window and a third on its 130th frame, so that the reset of the count and the drop both ask to act on that frame. The drop must win, leaving `err_cnt_o` at the threshold and not at 0. In the second, a relock pulse is driven together with a frame strobe that carries errors, and the frame must be discarded. A behavioural model predicts both outputs and is compared with them on every clock, through scripted phases and a long random phase.

// File: rtl/link_lock_monitor.sv
module link_lock_monitor #(
  parameter int WIN_LEN = 130,
  parameter logic [WIN_LEN-1:0] SEQ_PATTERN = 130'h3_1C2B_5A69_F0E4_D287_93A5_C6B1_0F2E,
  parameter int TH_W = 8,
  parameter int DEF_TH = 3,
  parameter logic CLK0_EXP = 1'b1,
  parameter logic CLK1_EXP = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            relock_i,
  input  logic            frame_vld_i,
  input  logic            clk_bit0_i,
  input  logic            clk_bit1_i,
  input  logic            enc_bit_i,
  input  logic [TH_W-1:0] thresh_i,
  input  logic            thresh_en_i,
  input  logic            clkchk_en_i,
  output logic            lock_o,
  output logic [TH_W-1:0] err_cnt_o
);
  localparam int IDX_W = $clog2(WIN_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_LEN - 1);

  logic [IDX_W-1:0] idx_q;
  logic [TH_W-1:0]  cnt_q;
  logic             lock_q;

  logic [1:0]      clk_errs;
  logic            seq_err;
  logic [1:0]      frame_errs;
  logic [TH_W-1:0] eff_th;
  logic [TH_W:0]   sum;
  logic            hit;
  logic            step;

  assign clk_errs   = clkchk_en_i ? ({1'b0, clk_bit0_i != CLK0_EXP} + {1'b0, clk_bit1_i != CLK1_EXP}) : 2'd0;
  assign seq_err    = enc_bit_i != SEQ_PATTERN[idx_q];
  assign frame_errs = clk_errs + {1'b0, seq_err};
  assign eff_th     = !thresh_en_i ? TH_W'(DEF_TH) : (thresh_i == '0) ? TH_W'(1) : thresh_i;
  assign sum        = {1'b0, cnt_q} + (TH_W+1)'(frame_errs);
  assign hit        = sum >= {1'b0, eff_th};
  assign step       = lock_q && frame_vld_i && !relock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (relock_i) begin
      lock_q <= 1'b1;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (step) begin
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      if (hit) begin
        lock_q <= 1'b0;
        cnt_q  <= eff_th;
      end else if (idx_q == LAST_IDX) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= sum[TH_W-1:0];
      end
    end
  end

  assign lock_o    = lock_q;
  assign err_cnt_o = cnt_q;

  AST_RELOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    relock_i |=> lock_o && err_cnt_o == '0 && idx_q == '0); // R2
  AST_UNLOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o && !relock_i |=> !lock_o && $stable(err_cnt_o)); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o && !frame_vld_i && !relock_i |=> lock_o && $stable(err_cnt_o) && $stable(idx_q)); // R10
  AST_DROP_AT_TH: assert property (@(posedge clk) disable iff (!rst_n)
    step && hit |=> !lock_o && err_cnt_o == $past(eff_th)); // R9
  AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    step && !hit && idx_q == LAST_IDX |=> lock_o && err_cnt_o == '0 && idx_q == '0); // R6
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX); // R4
endmodule

// File: tb/sim_link_lock_monitor.sv
`timescale 1ns/1ps
module sim_link_lock_monitor;
  localparam int W = 130;
  localparam logic [W-1:0] PAT = 130'h2_9E4D_07B3_C85A_61F2_3D9C_A470_B5E8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic relock = 0, fv = 0, b0 = 1, b1 = 0, eb = 0, ten = 0, cen = 1;
  logic [7:0] th = 8'd0;
  logic lock;
  logic [7:0] cnt;

  always #2.5 clk = ~clk;

  link_lock_monitor #(.WIN_LEN(W), .SEQ_PATTERN(PAT), .TH_W(8), .DEF_TH(3)) u0 (
    .clk(clk), .rst_n(rst_n), .relock_i(relock), .frame_vld_i(fv),
    .clk_bit0_i(b0), .clk_bit1_i(b1), .enc_bit_i(eb), .thresh_i(th),
    .thresh_en_i(ten), .clkchk_en_i(cen), .lock_o(lock), .err_cnt_o(cnt));

  int checks = 0, fails = 0, cycles = 0;
  int m_lock = 0, m_cnt = 0, m_idx = 0;
  string req = "R1";

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired (%s) actual=hung expected=done", req);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic compare();
    checks++;
    if (lock !== (m_lock != 0) || cnt !== 8'(m_cnt)) begin
      fails++;
      $display("FAIL %s lock/cnt actual=%0b/%0d expected=%0d/%0d", req, lock, cnt, m_lock, m_cnt);
    end
  endtask

  // drive one cycle, predict, advance, compare
  task automatic cyc(input bit rl, input bit f, input bit e0, input bit e1, input bit ee);
    int errs, teff;
    relock = rl; fv = f;
    b0 = ~e0; b1 = e1;
    eb = PAT[m_idx] ^ ee;
    if (rl) begin
      m_lock = 1; m_cnt = 0; m_idx = 0;
    end else if (f && m_lock != 0) begin
      errs = int'(ee) + (cen ? int'(e0) + int'(e1) : 0);
      teff = !ten ? 3 : (th == 0 ? 1 : int'(th));
      if (m_cnt + errs >= teff) begin
        m_cnt = teff; m_lock = 0;
      end else if (m_idx == W - 1) m_cnt = 0;
      else m_cnt += errs;
      m_idx = (m_idx + 1) % W;
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic clean(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req = "R1"; compare();
    rst_n = 1'b1;
    @(negedge clk); compare();
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 1, 1);

    req = "R2"; cyc(1, 0, 0, 0, 0);
    req = "R4"; clean(300);
    req = "R10";
    for (int i = 0; i < 200; i++) cyc(0, i % 3 == 0, 0, 0, 0);

    req = "R6";
    cyc(1, 0, 0, 0, 0);
    for (int w = 0; w < 3; w++)
      for (int i = 0; i < W; i++) cyc(0, 1, 0, 0, i == 10 || i == 129);

    req = "R3"; cen = 0;
    for (int i = 0; i < 260; i++) cyc(0, 1, 1, 1, 0);
    cen = 1;
    cyc(0, 1, 1, 0, 0);
    cyc(0, 1, 0, 1, 0);

    req = "R7"; th = 8'd50; ten = 0;
    cyc(0, 1, 0, 0, 1);
    req = "R9"; clean(20);
    req = "R2"; cyc(1, 1, 1, 1, 1);
    cyc(0, 0, 0, 0, 0);

    req = "R5"; cyc(0, 1, 1, 1, 1);
    clean(5);

    req = "R8"; cyc(1, 0, 0, 0, 0); ten = 1; th = 8'd5;
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 1);
    cyc(1, 0, 0, 0, 0); th = 8'd0;
    cyc(0, 1, 0, 0, 1);
    ten = 0;

    req = "R9";
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < W; i++) cyc(0, 1, 0, 0, i == 3 || i == 4 || i == 129);
    clean(10);

    req = "R5";
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 2) begin
        ten = $urandom_range(0, 1);
        th = 8'($urandom_range(0, 8));
        cen = $urandom_range(0, 1);
      end
      cyc(r >= 98 || (m_lock == 0 && r > 90), r < 80,
          $urandom_range(0, 99) < 2, $urandom_range(0, 99) < 2, $urandom_range(0, 99) < 2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule